// File: doc/BRIEF.md
# DMA Transfer Command Splitter

This block sits between a command issuer and a memory bus. It accepts DMA commands and checks that each one is legal. A command names a local-store address, an external address, a byte count and a 5-bit tag. A list command instead names a starting local address and a number of elements. The elements themselves arrive one by one on a separate input stream. Each element carries its own byte count and external address.

Legal transfers are cut into bus requests of at most 128 bytes. Each request has a simple valid/acknowledge handshake. Completion or failure is then reported per tag.

Accepted commands go into a queue, so the issuer can carry on while earlier work is still draining. The block counts the commands it holds: accepted and not yet finished. It stops accepting when that count reaches its cap.

The splitting engine is one state machine with these states:

- IDLE: waits for a queued command.
- DECIDE: judges a plain transfer or the element count of a list.
- ELEM: takes the next list element.
- ISSUE: holds a bus request until it is acknowledged.
- DRAIN: discards the remaining elements of a failed list.
- FINISH: reports the result for the tag.

Its transitions are named as follows:

- IDLE→DECIDE: a command is popped from the queue.
- DECIDE→ISSUE: the plain transfer is legal.
- DECIDE→ELEM: the list length is legal.
- DECIDE→FINISH: the transfer or list length is illegal.
- ELEM→ISSUE: the element is legal.
- ELEM→FINISH: the element has zero size, or the last element is illegal.
- ELEM→DRAIN: an illegal element is not the last one.
- ISSUE→ISSUE: more segments remain.
- ISSUE→ELEM: the transfer is done and list elements remain.
- ISSUE→FINISH: the whole command is done.
- DRAIN→FINISH: the last element has been discarded.
- FINISH→IDLE: always taken.

Top module: `xfer_splitter`

## Requirements
- R1: A transfer size is legal only if it is 1, 2, 4 or 8, or a nonzero multiple of 16 no larger than 16384. A plain command with any other size, 0 included, sets `tag_err[tag]`, clears `tag_done[tag]` and issues no bus request.
- R2: For sizes 2, 4 and 8, both the local and the external address must be multiples of the size. For multiples of 16, both addresses must be multiples of 16. A violation is handled as in R1.
- R3: A legal transfer is issued as bus requests with nonzero length of at most 128 bytes. No request spans a 128-byte boundary of the external address. Requests follow ascending, gap-free local and external addresses, and their lengths sum to the transfer size.
- R4: When every request of a command has been acknowledged, `tag_done[tag]` is set and `tag_err[tag]` is cleared. Accepting a command clears both bits of its tag. The two bits of a tag are never both set.
- R5: `pending` counts commands that have been accepted and not yet finished. `cmd_ready` is low while `pending` equals 16, and no command is accepted then.
- R6: Commands are accepted while earlier commands still hold a bus request open.
- R7: A list command (`cmd_list`=1) with `cmd_nelem` from 1 to 2048 takes elements strictly in order. The local address runs on from one element to the next. A list length of 0 or above 2048 is reported as an error and takes no elements.
- R8: A list element of size 0 ends its list with success. No further element is taken for that list.
- R9: An illegal list element sets the error bit and issues no request. The remaining elements of the list are taken and discarded.
- R10: After reset, `pending`, `tag_done` and `tag_err` are zero, `req_valid` and `elem_ready` are low, and `cmd_ready` is high.
- R11: Once raised, `req_valid` stays high with stable address and length until `req_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_list | input | 1 | 1 = list command |
| cmd_tag | input | 5 | Completion tag |
| cmd_laddr | input | 18 | Local-store address |
| cmd_eaddr | input | 32 | External address (plain commands) |
| cmd_size | input | 15 | Byte count (plain commands) |
| cmd_nelem | input | 12 | Element count (list commands) |
| elem_valid | input | 1 | List element offered |
| elem_ready | output | 1 | List element taken |
| elem_size | input | 15 | Element byte count |
| elem_eaddr | input | 32 | Element external address |
| req_valid | output | 1 | Bus request present |
| req_ack | input | 1 | Bus request accepted |
| req_laddr | output | 18 | Request local address |
| req_eaddr | output | 32 | Request external address |
| req_len | output | 8 | Request length in bytes (1..128) |
| pending | output | 5 | Commands held |
| tag_done | output | 32 | Per-tag success bits |
| tag_err | output | 32 | Per-tag error bits |

## Verification
The splitter is tested with three groups of input patterns:

- Every small size, with its legal alignment.
- Multiples of 16 placed on a 128-byte boundary, just after one, and just before one. These separate a correct boundary cut from one that only limits length.
- Maximal transfers with and without an offset, which tell 128 from 129 requests.

Illegal sizes and misaligned local or external addresses check that errors produce no traffic. Three list cases are run: a normal list, a list ended early by a zero-size element, and a list with a bad middle element. They show whether elements are consumed in order, stopped at the right point, or drained. With acknowledges withheld, the bench fills the command count to its cap to show that acceptance continues while requests are open and that it stops exactly at the cap.

// File: rtl/xs_pkg.sv
package xs_pkg;
    localparam int TAG_W = 5;
    localparam int LA_W  = 18;
    localparam int EA_W  = 32;
    localparam int SZ_W  = 15;
    localparam int CNT_W = 12;

    typedef struct packed {
        logic             is_list;
        logic [TAG_W-1:0] tag;
        logic [LA_W-1:0]  la;
        logic [EA_W-1:0]  ea;
        logic [SZ_W-1:0]  size;
        logic [CNT_W-1:0] nelem;
    } cmd_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_ELEM,
        ST_ISSUE,
        ST_DRAIN,
        ST_FINISH
    } eng_state_t;
endpackage

// File: rtl/xs_cmd_fifo.sv
module xs_cmd_fifo
    import xs_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  cmd_t din,
    input  logic pop,
    output cmd_t dout,
    output logic empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    cmd_t          mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= (int'(wr_ptr) == DEPTH - 1) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (int'(rd_ptr) == DEPTH - 1) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign dout  = mem[rd_ptr];
    assign empty = (count == '0);

    assert_fifo_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (int'(count) < DEPTH));
    assert_fifo_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));
endmodule

// File: rtl/xs_tag_track.sv
module xs_tag_track
    import xs_pkg::*;
#(
    parameter  int MAX_PEND = 16,
    localparam int PEND_W   = $clog2(MAX_PEND + 1),
    localparam int NTAG     = 1 << TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic [TAG_W-1:0]  acc_tag,
    input  logic              fin,
    input  logic              fin_err,
    input  logic [TAG_W-1:0]  fin_tag,
    output logic              ready,
    output logic [PEND_W-1:0] pending,
    output logic [NTAG-1:0]   done,
    output logic [NTAG-1:0]   err
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
            done    <= '0;
            err     <= '0;
        end else begin
            unique case ({acc, fin})
                2'b10:   pending <= pending + 1'b1;
                2'b01:   pending <= pending - 1'b1;
                default: pending <= pending;
            endcase
            if (fin) begin
                done[fin_tag] <= !fin_err;
                err[fin_tag]  <= fin_err;
            end
            if (acc) begin
                done[acc_tag] <= 1'b0;
                err[acc_tag]  <= 1'b0;
            end
        end
    end

    assign ready = (int'(pending) < MAX_PEND);

    assert_pend_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pending) <= MAX_PEND);
    assert_pend_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !fin) |=> (pending == $past(pending) + 1'b1));
    assert_done_err_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done & err) == '0);
endmodule

// File: rtl/xs_seg_engine.sv
module xs_seg_engine
    import xs_pkg::*;
#(
    parameter  int SEG_BYTES = 128,
    parameter  int MAX_XFER  = 16384,
    parameter  int MAX_LIST  = 2048,
    localparam int SEG_W     = $clog2(SEG_BYTES + 1),
    localparam int OFF_W     = $clog2(SEG_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             q_empty,
    input  cmd_t             head,
    output logic             pop,
    input  logic             elem_valid,
    output logic             elem_ready,
    input  logic [SZ_W-1:0]  elem_size,
    input  logic [EA_W-1:0]  elem_ea,
    output logic             req_valid,
    input  logic             req_ack,
    output logic [LA_W-1:0]  req_la,
    output logic [EA_W-1:0]  req_ea,
    output logic [SEG_W-1:0] req_len,
    output logic             fin,
    output logic             fin_err,
    output logic [TAG_W-1:0] fin_tag
);
    eng_state_t       state_q, state_d;
    logic             cur_list;
    logic [TAG_W-1:0] cur_tag;
    logic [LA_W-1:0]  cur_la;
    logic [EA_W-1:0]  cur_ea;
    logic [SZ_W-1:0]  rem;
    logic [CNT_W-1:0] left;
    logic             err_r;
    logic [SZ_W-1:0]  room;
    logic [SZ_W-1:0]  seg;
    logic             plain_ok;
    logic             elem_ok;
    logic             list_ok;
    logic             seg_last;

    function automatic logic legal_xfer(input logic [SZ_W-1:0] sz,
                                        input logic [EA_W-1:0] ea,
                                        input logic [LA_W-1:0] la);
        logic ok;
        if (sz == SZ_W'(1))
            ok = 1'b1;
        else if (sz == SZ_W'(2))
            ok = !ea[0] && !la[0];
        else if (sz == SZ_W'(4))
            ok = (ea[1:0] == 2'b00) && (la[1:0] == 2'b00);
        else if (sz == SZ_W'(8))
            ok = (ea[2:0] == 3'b000) && (la[2:0] == 3'b000);
        else
            ok = (sz != '0) && (sz[3:0] == 4'h0) && (int'(sz) <= MAX_XFER)
                 && (ea[3:0] == 4'h0) && (la[3:0] == 4'h0);
        return ok;
    endfunction

    always_comb begin
        room     = SZ_W'(SEG_BYTES) - SZ_W'(cur_ea[OFF_W-1:0]);
        seg      = (rem < room) ? rem : room;
        seg_last = (rem == seg);
        plain_ok = legal_xfer(rem, cur_ea, cur_la);
        elem_ok  = legal_xfer(elem_size, elem_ea, cur_la);
        list_ok  = (left != '0) && (int'(left) <= MAX_LIST);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!q_empty) state_d = ST_DECIDE;
            ST_DECIDE: begin
                if (cur_list) state_d = list_ok ? ST_ELEM : ST_FINISH;
                else          state_d = plain_ok ? ST_ISSUE : ST_FINISH;
            end
            ST_ELEM: begin
                if (elem_valid) begin
                    if (elem_size == '0)  state_d = ST_FINISH;
                    else if (elem_ok)     state_d = ST_ISSUE;
                    else if (left == 1)   state_d = ST_FINISH;
                    else                  state_d = ST_DRAIN;
                end
            end
            ST_ISSUE: begin
                if (req_ack && seg_last)
                    state_d = (cur_list && left != '0) ? ST_ELEM : ST_FINISH;
            end
            ST_DRAIN:  if (elem_valid && left == 1) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_list <= 1'b0;
            cur_tag  <= '0;
            cur_la   <= '0;
            cur_ea   <= '0;
            rem      <= '0;
            left     <= '0;
            err_r    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!q_empty) begin
                        cur_list <= head.is_list;
                        cur_tag  <= head.tag;
                        cur_la   <= head.la;
                        cur_ea   <= head.ea;
                        rem      <= head.size;
                        left     <= head.nelem;
                        err_r    <= 1'b0;
                    end
                end
                ST_DECIDE: begin
                    if (cur_list ? !list_ok : !plain_ok) err_r <= 1'b1;
                end
                ST_ELEM: begin
                    if (elem_valid) begin
                        left <= left - 1'b1;
                        if (elem_size != '0) begin
                            if (elem_ok) begin
                                rem    <= elem_size;
                                cur_ea <= elem_ea;
                            end else begin
                                err_r <= 1'b1;
                            end
                        end
                    end
                end
                ST_ISSUE: begin
                    if (req_ack) begin
                        rem    <= rem - seg;
                        cur_ea <= cur_ea + EA_W'(seg);
                        cur_la <= cur_la + LA_W'(seg);
                    end
                end
                ST_DRAIN:  if (elem_valid) left <= left - 1'b1;
                ST_FINISH: ;
                default:   ;
            endcase
        end
    end

    // outputs
    always_comb begin
        pop        = (state_q == ST_IDLE) && !q_empty;
        elem_ready = (state_q == ST_ELEM) || (state_q == ST_DRAIN);
        req_valid  = (state_q == ST_ISSUE);
        req_la     = cur_la;
        req_ea     = cur_ea;
        req_len    = SEG_W'(seg);
        fin        = (state_q == ST_FINISH);
        fin_err    = err_r;
        fin_tag    = cur_tag;
    end

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_ea) && $stable(req_la)
                                     && $stable(req_len)));
    assert_seg_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_len != '0 && int'(req_len) <= SEG_BYTES
                       && int'(req_ea[OFF_W-1:0]) + int'(req_len) <= SEG_BYTES));
    assert_elem_only_list_R7: assert property (@(posedge clk) disable iff (!rst_n)
        elem_ready |-> cur_list);
    assert_err_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !err_r);
endmodule

// File: rtl/xfer_splitter.sv
module xfer_splitter
    import xs_pkg::*;
#(
    parameter  int MAX_PEND  = 16,
    parameter  int SEG_BYTES = 128,
    parameter  int MAX_XFER  = 16384,
    parameter  int MAX_LIST  = 2048,
    localparam int PEND_W    = $clog2(MAX_PEND + 1),
    localparam int SEG_W     = $clog2(SEG_BYTES + 1),
    localparam int NTAG      = 1 << TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_list,
    input  logic [TAG_W-1:0]  cmd_tag,
    input  logic [LA_W-1:0]   cmd_laddr,
    input  logic [EA_W-1:0]   cmd_eaddr,
    input  logic [SZ_W-1:0]   cmd_size,
    input  logic [CNT_W-1:0]  cmd_nelem,
    input  logic              elem_valid,
    output logic              elem_ready,
    input  logic [SZ_W-1:0]   elem_size,
    input  logic [EA_W-1:0]   elem_eaddr,
    output logic              req_valid,
    input  logic              req_ack,
    output logic [LA_W-1:0]   req_laddr,
    output logic [EA_W-1:0]   req_eaddr,
    output logic [SEG_W-1:0]  req_len,
    output logic [PEND_W-1:0] pending,
    output logic [NTAG-1:0]   tag_done,
    output logic [NTAG-1:0]   tag_err
);
    cmd_t             in_cmd;
    cmd_t             head;
    logic             accept;
    logic             q_empty;
    logic             pop;
    logic             fin;
    logic             fin_err;
    logic [TAG_W-1:0] fin_tag;

    assign accept = cmd_valid && cmd_ready;

    always_comb begin
        in_cmd.is_list = cmd_list;
        in_cmd.tag     = cmd_tag;
        in_cmd.la      = cmd_laddr;
        in_cmd.ea      = cmd_eaddr;
        in_cmd.size    = cmd_size;
        in_cmd.nelem   = cmd_nelem;
    end

    xs_cmd_fifo #(.DEPTH(MAX_PEND)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (accept),
        .din   (in_cmd),
        .pop   (pop),
        .dout  (head),
        .empty (q_empty)
    );

    xs_seg_engine #(
        .SEG_BYTES (SEG_BYTES),
        .MAX_XFER  (MAX_XFER),
        .MAX_LIST  (MAX_LIST)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .q_empty    (q_empty),
        .head       (head),
        .pop        (pop),
        .elem_valid (elem_valid),
        .elem_ready (elem_ready),
        .elem_size  (elem_size),
        .elem_ea    (elem_eaddr),
        .req_valid  (req_valid),
        .req_ack    (req_ack),
        .req_la     (req_laddr),
        .req_ea     (req_eaddr),
        .req_len    (req_len),
        .fin        (fin),
        .fin_err    (fin_err),
        .fin_tag    (fin_tag)
    );

    xs_tag_track #(.MAX_PEND(MAX_PEND)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (accept),
        .acc_tag (cmd_tag),
        .fin     (fin),
        .fin_err (fin_err),
        .fin_tag (fin_tag),
        .ready   (cmd_ready),
        .pending (pending),
        .done    (tag_done),
        .err     (tag_err)
    );

    assert_cap_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(pending) == MAX_PEND && !fin) |=> (int'(pending) == MAX_PEND));
endmodule

// File: tb/xfer_splitter_test.sv
`timescale 1ns/1ps
module xfer_splitter_test;
    import xs_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_list = 1'b0;
    logic [4:0]  cmd_tag = '0;
    logic [17:0] cmd_laddr = '0;
    logic [31:0] cmd_eaddr = '0;
    logic [14:0] cmd_size = '0;
    logic [11:0] cmd_nelem = '0;
    logic        elem_valid = 1'b0;
    logic        elem_ready;
    logic [14:0] elem_size = '0;
    logic [31:0] elem_eaddr = '0;
    logic        req_valid;
    logic        req_ack = 1'b0;
    logic [17:0] req_laddr;
    logic [31:0] req_eaddr;
    logic [7:0]  req_len;
    logic [4:0]  pending;
    logic [31:0] tag_done;
    logic [31:0] tag_err;

    xfer_splitter uut (.*);

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit ack_en = 1'b1;
    bit ord_on = 1'b0;
    int rq_n = 0;
    longint rq_bytes = 0;
    int bnd_bad = 0;
    int ord_bad = 0;
    logic [31:0] x_ea = '0;
    logic [17:0] x_la = '0;

    localparam int NV = 17;
    localparam int V_SZ  [NV] = '{1, 2, 4, 8, 16, 128, 128, 256, 16384, 16384,
                                  3, 16400, 0, 4, 48, 32, 24};
    localparam int V_EA  [NV] = '{'h1003, 'h1002, 'h1004, 'h2008, 'h3070, 'h4000, 'h4010,
                                  'h5040, 'h10000, 'h20010, 'h1000, 0, 0, 'h1002, 'h208,
                                  'h1000, 'h1000};
    localparam int V_LA  [NV] = '{'h5, 'h10, 'h8, 'h18, 'h100, 'h200, 'h300, 'h400,
                                  'h8000, 'h10000, 0, 0, 0, 0, 0, 'h4, 0};
    localparam int V_NRQ [NV] = '{1, 1, 1, 1, 1, 1, 2, 3, 128, 129,
                                  0, 0, 0, 0, 0, 0, 0};
    localparam int V_ERR [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0,
                                  1, 1, 1, 1, 1, 1, 1};
    localparam int V_RQ  [NV] = '{3, 3, 3, 3, 3, 3, 3, 3, 3, 3,
                                  1, 1, 1, 2, 2, 2, 1};

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string rq_name(input int k);
        case (k)
            1: return "R1";
            2: return "R2";
            default: return "R3";
        endcase
    endfunction

    // bus responder: logs each request once, then acknowledges it
    always @(negedge clk) begin
        if (req_valid && !req_ack && ack_en) begin
            rq_n     = rq_n + 1;
            rq_bytes = rq_bytes + req_len;
            if (req_len == 0 || req_len > 128 || (req_eaddr % 128) + req_len > 128)
                bnd_bad = bnd_bad + 1;
            if (ord_on && (req_eaddr != x_ea || req_laddr != x_la))
                ord_bad = ord_bad + 1;
            x_ea = req_eaddr + 32'(req_len);
            x_la = req_laddr + 18'(req_len);
            req_ack <= 1'b1;
        end else begin
            req_ack <= 1'b0;
        end
    end

    task automatic send_cmd(input bit lst, input int tag, input int la, input int ea,
                            input int sz, input int ne);
        @(negedge clk);
        cmd_list  = lst;
        cmd_tag   = 5'(tag);
        cmd_laddr = 18'(la);
        cmd_eaddr = 32'(ea);
        cmd_size  = 15'(sz);
        cmd_nelem = 12'(ne);
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_elem(input int sz, input int ea);
        @(negedge clk);
        elem_size  = 15'(sz);
        elem_eaddr = 32'(ea);
        elem_valid = 1'b1;
        while (!elem_ready) @(negedge clk);
        x_ea = 32'(ea);
        @(posedge clk);
        @(negedge clk);
        elem_valid = 1'b0;
    endtask

    task automatic wait_tag(input int t);
        int n = 0;
        @(negedge clk);
        while (!(tag_done[t] || tag_err[t]) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic clr_log(input int ea, input int la);
        rq_n = 0; rq_bytes = 0; bnd_bad = 0; ord_bad = 0;
        x_ea = 32'(ea); x_la = 18'(la);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 pending", pending, 0);
        chk("R10 done", tag_done, 0);
        chk("R10 err", tag_err, 0);
        chk("R10 req_valid", req_valid, 0);
        chk("R10 elem_ready", elem_ready, 0);
        chk("R10 cmd_ready", cmd_ready, 1);

        // table of plain transfers
        ord_on = 1'b1;
        for (int i = 0; i < NV; i++) begin
            string rn;
            rn = rq_name(V_RQ[i]);
            clr_log(V_EA[i], V_LA[i]);
            send_cmd(1'b0, i, V_LA[i], V_EA[i], V_SZ[i], 0);
            wait_tag(i);
            chk({rn, " request count"}, rq_n, V_NRQ[i]);
            chk({rn, " byte total"}, rq_bytes, V_ERR[i] ? 0 : V_SZ[i]);
            chk({rn, " err bit"}, tag_err[i], V_ERR[i]);
            chk({"R4 done bit ", rn}, tag_done[i], 1 - V_ERR[i]);
            chk("R3 boundary", bnd_bad, 0);
            chk("R3 order", ord_bad, 0);
        end
        chk("R5 pending drained", pending, 0);

        // R7: normal list of three elements
        clr_log(0, 'h1000);
        send_cmd(1'b1, 20, 'h1000, 0, 0, 3);
        send_elem(16, 'h100);
        send_elem(256, 'h2F0);
        send_elem(8, 'h408);
        wait_tag(20);
        chk("R7 list requests", rq_n, 5);
        chk("R7 list bytes", rq_bytes, 280);
        chk("R7 list done", tag_done[20], 1);
        chk("R7 list order", ord_bad, 0);
        chk("R3 list boundary", bnd_bad, 0);
        chk("R7 elem_ready idle", elem_ready, 0);

        // R8: zero-size element ends the list
        clr_log(0, 'h2000);
        send_cmd(1'b1, 21, 'h2000, 0, 0, 4);
        send_elem(32, 'h800);
        send_elem(0, 0);
        wait_tag(21);
        chk("R8 early end done", tag_done[21], 1);
        chk("R8 early end err", tag_err[21], 0);
        chk("R8 early end requests", rq_n, 1);
        repeat (4) @(negedge clk);
        chk("R8 no further element taken", elem_ready, 0);
        chk("R8 pending", pending, 0);

        // R9: illegal middle element, rest drained
        clr_log(0, 'h3000);
        send_cmd(1'b1, 22, 'h3000, 0, 0, 3);
        send_elem(16, 'h900);
        send_elem(3, 'h950);
        send_elem(64, 'hA00);
        wait_tag(22);
        chk("R9 err bit", tag_err[22], 1);
        chk("R9 done bit", tag_done[22], 0);
        chk("R9 requests", rq_n, 1);
        chk("R9 bytes", rq_bytes, 16);
        chk("R9 drained", elem_ready, 0);

        // R7: illegal list lengths
        clr_log(0, 0);
        send_cmd(1'b1, 23, 0, 0, 0, 0);
        wait_tag(23);
        chk("R7 empty list err", tag_err[23], 1);
        chk("R7 empty list no element", elem_ready, 0);
        send_cmd(1'b1, 24, 0, 0, 0, 2049);
        wait_tag(24);
        chk("R7 long list err", tag_err[24], 1);
        chk("R7 long list requests", rq_n, 0);

        // R5/R6: cap of outstanding commands with acknowledges withheld
        ord_on = 1'b0;
        ack_en = 1'b0;
        for (int t = 0; t < 16; t++) begin
            send_cmd(1'b0, t, t * 16, t * 16, 16, 0);
            if (t == 2) chk("R6 accept while request open", req_valid && cmd_ready, 1);
        end
        chk("R5 pending full", pending, 16);
        chk("R5 cmd_ready low", cmd_ready, 0);
        @(negedge clk);
        cmd_list = 1'b0; cmd_tag = 5'd25; cmd_laddr = '0; cmd_eaddr = 32'h40;
        cmd_size = 15'd16; cmd_valid = 1'b1;
        repeat (5) @(negedge clk);
        chk("R5 refused while full", pending, 16);
        ack_en = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_tag(25);
        repeat (10) @(negedge clk);
        chk("R5 pending after drain", pending, 0);
        chk("R4 all tags done", tag_done[15:0], 16'hFFFF);
        chk("R4 old error bits cleared", tag_err[15:0], 0);
        chk("R4 late tag done", tag_done[25], 1);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule